// File: doc/BRIEF.md
# Burst Column Address Generator

This block sequences the column address of a synchronous DRAM read or write burst. A one-cycle start pulse captures a starting column, a burst-length code and an ordering selection. From the next clock the block presents one column per cycle on `col_o` with `valid_o` high. `last_o` marks the final beat of a fixed-length burst. The memory array, the data path, command decoding and read-latency pipelining are left to the surrounding logic.

Two orderings are available. Sequential ordering counts upward and wraps inside the aligned burst window. Interleaved ordering flips the low column bits by the beat number. A full-page length runs through every column of the row, wrapping at the row end, and continues until it is cut off. A burst can end early on any cycle through `term_i`. A new start pulse can also replace it on any cycle, including the last beat, so bursts can follow each other with no gap. When interleaved ordering is requested together with full page, the block runs a sequential full-page burst and raises `cfg_err_o`.

The controller has three states:
- `ST_IDLE`: no burst.
- `ST_BURST`: fixed length.
- `ST_PAGE`: full page.

Its transitions are:
- start (from any state) goes to `ST_BURST` or `ST_PAGE`, depending on the length code.
- final-beat in `ST_BURST` goes to `ST_IDLE`.
- terminate in `ST_BURST` or `ST_PAGE` goes to `ST_IDLE`.
- hold keeps `ST_BURST` or `ST_PAGE` otherwise.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and after it until the first start, `valid_o`, `last_o` and `cfg_err_o` are 0 and `col_o` is 0.
- R2: A start sampled on a rising edge makes `valid_o` 1 and `col_o` equal to the sampled start column after that same edge (beat 0).
- R3: Length code `blen_i`: with bit 2 at 0, bits [1:0] = 0, 1, 2, 3 select a length BL of 1, 2, 4, 8. With bit 2 at 1, the length is full page (256 columns).
- R4: Sequential ordering (`ilv_i`=0), fixed length: beat n shows the start column with its low log2(BL) bits replaced by (start + n) mod BL; the upper bits are unchanged.
- R5: Interleaved ordering (`ilv_i`=1), fixed length: beat n shows the start column XOR n.
- R6: A fixed-length burst keeps `valid_o` high for exactly BL cycles; `last_o` is high only on the final beat (for BL=1 that is beat 0); `valid_o` is 0 afterwards.
- R7: A full-page burst steps the column by 1 modulo 256 every cycle, never raises `last_o`, and runs until terminated.
- R8: A terminate sampled on an edge with no start makes `valid_o` 0 after that edge.
- R9: A start sampled during a burst replaces it and restarts from the new column. When start and terminate are sampled together, start wins.
- R10: A start sampled on the final beat gives a gapless next burst; `valid_o` stays high.
- R11: Interleaved ordering with full-page length runs as a sequential full-page burst. `cfg_err_o` is 1 from the next cycle until the next start with a legal setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a new burst this cycle |
| start_col_i | input | 8 | Starting column |
| blen_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| term_i | input | 1 | Terminate the burst in progress |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Current burst was started with an illegal setting |

## Verification
A corrupted beat counter or captured mask shows up on `col_o` within one cycle of the bad value. It also moves `last_o` and the fall of `valid_o` away from the cycle BL beats after the start. A wrong state shows up as a burst that ends too early or runs on past its length. A wrong state also appears as a full-page burst that raises `last_o`, or as a terminate that leaves `valid_o` high on the following cycle. Each of these is visible no later than the beat after the fault.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam int LEN_CODE_W = 3;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] blen_i,
    input  logic                  ilv_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      base_o,
    output logic [COL_W-1:0]      cnt_o,
    output logic [COL_W-1:0]      mask_o,
    output logic                  ilv_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  err_o
);
    bcg_state_e       state_q, state_nx;
    logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_new;
    logic             ilv_q, err_q;
    logic             page_req;

    assign page_req = blen_i[2];
    assign mask_new = page_req ? {COL_W{1'b1}}
                               : ((COL_W'(1) << blen_i[1:0]) - COL_W'(1));

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  state_nx = ST_IDLE;
            ST_BURST: begin
                if (term_i || cnt_q == mask_q) state_nx = ST_IDLE;
            end
            ST_PAGE: begin
                if (term_i) state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
        if (start_i) state_nx = page_req ? ST_PAGE : ST_BURST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            cnt_q  <= '0;
            mask_q <= mask_new;
            ilv_q  <= ilv_i & ~page_req;
            err_q  <= ilv_i & page_req;
        end else if (state_q != ST_IDLE) begin
            cnt_q  <= cnt_q + COL_W'(1);
        end
    end

    always_comb begin
        base_o  = base_q;
        cnt_o   = cnt_q;
        mask_o  = mask_q;
        ilv_o   = ilv_q;
        err_o   = err_q;
        valid_o = (state_q != ST_IDLE);
        last_o  = (state_q == ST_BURST) && (cnt_q == mask_q);
    end
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr #(
    parameter int COL_W = 8
) (
    input  logic             valid_i,
    input  logic             ilv_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_col, ilv_col;

    assign seq_col = (base_i & ~mask_i) | ((base_i + cnt_i) & mask_i);
    assign ilv_col = base_i ^ (cnt_i & mask_i);

    always_comb begin
        if (!valid_i)   col_o = '0;
        else if (ilv_i) col_o = ilv_col;
        else            col_o = seq_col;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    logic [COL_W-1:0] base_w, cnt_w, mask_w;
    logic             ilv_w;

    bcg_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i),
        .base_o(base_w), .cnt_o(cnt_w), .mask_o(mask_w), .ilv_o(ilv_w),
        .valid_o(valid_o), .last_o(last_o), .err_o(cfg_err_o)
    );

    bcg_addr #(.COL_W(COL_W)) addr_i (
        .valid_i(valid_o), .ilv_i(ilv_w), .base_i(base_w),
        .cnt_i(cnt_w), .mask_i(mask_w), .col_o(col_o)
    );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_i,
    input logic             ilv_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             cfg_err_o
);
    logic page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       page_q <= 1'b0;
        else if (start_i) page_q <= blen_i[2];
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            idle_rst_chk: assert (!valid_o && !last_o && !cfg_err_o && col_o == '0);
        end
    end

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o && col_o == $past(start_col_i));

    // R6
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !valid_o);

    // R7
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && page_q && !start_i && !term_i |=>
            valid_o && !last_o && col_o == $past(col_o) + COL_W'(1));

    // R8
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_i && !start_i |=> !valid_o);

    // R11
    cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> cfg_err_o == ($past(ilv_i) && $past(blen_i[2])));

    // R11
    cfg_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(cfg_err_o));
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o, last_o, cfg_err_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i), .col_o(col_o),
        .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    // {ilv, blen[2:0], start column}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 3'd0, 8'h37}, {1'b0, 3'd1, 8'h35},
        {1'b0, 3'd2, 8'h5E}, {1'b0, 3'd3, 8'hFD},
        {1'b1, 3'd1, 8'h21}, {1'b1, 3'd2, 8'h06},
        {1'b1, 3'd3, 8'h9B}, {1'b1, 3'd0, 8'hC4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int blen_len(input logic [2:0] bl);
        return bl[2] ? 256 : (1 << bl[1:0]);
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] base, input logic ilv,
                                           input logic [2:0] bl, input int n);
        int len = blen_len(bl);
        int low = base % len;
        int up  = base - low;
        if (ilv && !bl[2]) return base ^ 8'(n);
        return 8'(up + ((low + n) % len));
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic go(input logic ilv, input logic [2:0] bl, input logic [7:0] col, input logic trm);
        start_i = 1'b1; ilv_i = ilv; blen_i = bl; start_col_i = col; term_i = trm;
        tick();
        start_i = 1'b0; term_i = 1'b0;
    endtask

    task automatic beats(input string req, input logic ilv, input logic [2:0] bl,
                         input logic [7:0] col, input int first, input int n);
        for (int k = first; k < first + n; k++) begin
            logic exp_last;
            exp_last = !bl[2] && (k == blen_len(bl) - 1);
            check(valid_o && col_o == exp_col(col, ilv, bl, k) && last_o == exp_last,
                  req, {valid_o, last_o, col_o}, {1'b1, exp_last, exp_col(col, ilv, bl, k)});
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1 during and after reset
        check(!valid_o && !last_o && !cfg_err_o && col_o == 0, "R1 in reset",
              {valid_o, last_o, cfg_err_o, col_o}, 0);
        rst_n = 1'b1;
        tick();
        check(!valid_o && !last_o && !cfg_err_o && col_o == 0, "R1 after reset",
              {valid_o, last_o, cfg_err_o, col_o}, 0);

        // R2 R3 R4 R5 R6: vector table
        for (int v = 0; v < 8; v++) begin
            logic       vi = VEC[v][11];
            logic [2:0] vb = VEC[v][10:8];
            logic [7:0] vc = VEC[v][7:0];
            go(vi, vb, vc, 1'b0);
            check(col_o == vc, "R2 beat0", col_o, vc);
            beats(vi ? "R5 interleaved" : "R4 sequential", vi, vb, vc, 0, blen_len(vb));
            check(!valid_o && !last_o, "R6 end of burst", valid_o, 0);
            tick();
        end

        // R7 full page with wrap, then terminate (R8)
        go(1'b0, 3'd4, 8'hFE, 1'b0);
        beats("R7 full page", 1'b0, 3'd4, 8'hFE, 0, 260);
        term_i = 1'b1; tick(); term_i = 1'b0;
        check(!valid_o, "R8 terminate page", valid_o, 0);
        check(!cfg_err_o, "R11 legal page no error", cfg_err_o, 0);
        tick();

        // R8 terminate mid fixed burst
        go(1'b0, 3'd3, 8'h10, 1'b0);
        beats("R4 before term", 1'b0, 3'd3, 8'h10, 0, 3);
        term_i = 1'b1; tick(); term_i = 1'b0;
        check(!valid_o, "R8 terminate burst", valid_o, 0);
        tick();
        check(!valid_o && col_o == 0, "R8 stays idle", valid_o, 0);

        // R9 restart mid burst
        go(1'b1, 3'd3, 8'h40, 1'b0);
        beats("R5 before restart", 1'b1, 3'd3, 8'h40, 0, 2);
        go(1'b0, 3'd2, 8'h83, 1'b0);
        beats("R9 restart", 1'b0, 3'd2, 8'h83, 0, 4);
        check(!valid_o, "R9 restart end", valid_o, 0);

        // R9 start wins over terminate
        go(1'b0, 3'd3, 8'h00, 1'b0);
        beats("R4 before clash", 1'b0, 3'd3, 8'h00, 0, 2);
        go(1'b1, 3'd1, 8'h71, 1'b1);
        beats("R9 start beats term", 1'b1, 3'd1, 8'h71, 0, 2);
        check(!valid_o, "R9 clash end", valid_o, 0);

        // R10 back-to-back on final beat
        go(1'b0, 3'd1, 8'h22, 1'b0);
        beats("R10 first", 1'b0, 3'd1, 8'h22, 0, 1);
        check(last_o, "R10 last before chain", last_o, 1);
        go(1'b0, 3'd1, 8'h55, 1'b0);
        beats("R10 chained", 1'b0, 3'd1, 8'h55, 0, 2);
        check(!valid_o, "R10 chain end", valid_o, 0);

        // R11 illegal interleaved full page
        go(1'b1, 3'd7, 8'hFD, 1'b0);
        check(cfg_err_o, "R11 error raised", cfg_err_o, 1);
        beats("R11 sequential page", 1'b0, 3'd7, 8'hFD, 0, 6);
        term_i = 1'b1; tick(); term_i = 1'b0;
        check(cfg_err_o && !valid_o, "R11 error held after term", {cfg_err_o, valid_o}, 2);
        go(1'b0, 3'd0, 8'h09, 1'b0);
        check(!cfg_err_o, "R11 error cleared", cfg_err_o, 0);
        beats("R6 BL1", 1'b0, 3'd0, 8'h09, 0, 1);
        check(!valid_o, "R6 BL1 end", valid_o, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule